// File: doc/BRIEF.md
# Write Burst Disconnect Boundary Controller

This block sits on the target side of a bus bridge. It watches an incoming write burst and decides on which data phase the bridge should end the burst with a target disconnect. A pulse on `burst_start` loads the starting DWORD address and the transaction kind. The block then keeps a running DWORD address that advances on every accepted data phase. It raises `disconnect` during the data phase whose next address would cross the boundary that applies.

The boundary depends on several inputs. These are the transaction kind, the memory-write disconnect control bit (bit 1 of the chip control word), the programmed cache line size in DWORDs, and the live free-DWORD count of the posted write data buffer. A delayed write always stops after one transfer. A posted write also stops as soon as the buffer is about to run out of room. When more than one stopping point applies, the earliest one in the burst is taken. The buffer storage and the bus handshake are outside this block.

Top module: `burst_disconnect_ctl`

## Requirements
- R1: One cycle after a `burst_start` pulse, `busy` is 1 and `cur_addr` equals the `burst_addr` sampled on that pulse. A pulse while busy restarts the burst. After reset, `busy`, `disconnect` and `cur_addr` are 0.
- R2: Each cycle with `phase_ok`=1 while busy (and no `burst_start`) increments `cur_addr` by one. While idle, `cur_addr` holds.
- R3: `burst_kind` code 0 (delayed write, code 3 is treated the same way) raises `disconnect` on the first data phase, so the burst ends after exactly one transfer.
- R4: For both posted kinds, `disconnect` is 1 whenever the low 10 bits of `cur_addr` are all ones (the last DWORD of a 4KB page). For posted memory write (code 1) with `chip_ctl[1]`=0, this is the only address boundary.
- R5: For posted memory write with `chip_ctl[1]`=1 and a cache line size of 1, 2, 4, 8 or 16, `disconnect` is 1 when `cur_addr` mod line size equals line size minus 1. With any other line size, only the R4 boundary applies.
- R6: For write-and-invalidate (code 2) with a cache line size outside {1,2,4,8,16}, only the R4 boundary applies.
- R7: For write-and-invalidate with a line size of 1, 2, 4 or 8, `disconnect` is 1 at the last DWORD of a line only if `buf_free_dw` <= line size. That is, after this DWORD the buffer cannot hold the next whole line.
- R8: For write-and-invalidate with a line size of 16, `disconnect` is 1 when the low 4 bits of `cur_addr` are all ones, whatever the buffer space.
- R9: For both posted kinds, `disconnect` is 1 whenever `buf_free_dw` <= 1, on any address.
- R10: `disconnect` is 0 while idle. An accepted phase with `disconnect`=1 ends the burst (`busy` is 0 next cycle). An accepted phase without it keeps the burst going.
- R11: Only bit 1 of `chip_ctl` affects behaviour; the other seven bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_start | input | 1 | Address phase: load address and kind |
| burst_kind | input | 2 | 0 delayed write, 1 posted memory write, 2 write-and-invalidate |
| burst_addr | input | ADDR_W | Starting DWORD address |
| phase_ok | input | 1 | Data phase accepted this cycle |
| cache_line_dw | input | CLS_W | Programmed cache line size in DWORDs |
| chip_ctl | input | 8 | Chip control word; bit 1 is the disconnect control bit |
| buf_free_dw | input | FREE_W | Free DWORDs in the posted buffer, counting the slot this phase uses |
| disconnect | output | 1 | Disconnect this data phase |
| busy | output | 1 | Burst in progress |
| cur_addr | output | ADDR_W | DWORD address of the current data phase |

## Verification
Some rules are checked by the assertions on every cycle, without any knowledge of line-size arithmetic:
- a delayed write disconnects at once;
- a posted burst stops when the buffer is nearly full or at a page end;
- there is no disconnect while idle;
- an accepted disconnect closes the burst;
- the address loads on start and steps by one.

The rules that depend on the control bit and on the cache line size can only be shown by the bench's scenarios. These are line ends for each legal and illegal size, the buffer-space test for write-and-invalidate, and the 16-DWORD block. The bench's reference model predicts, cycle by cycle, the exact phase on which each burst should stop.

// File: rtl/wbd_pkg.sv
package wbd_pkg;

    typedef enum logic [1:0] {
        WK_DELAYED = 2'd0,
        WK_POSTED  = 2'd1,
        WK_INVAL   = 2'd2,
        WK_RSVD    = 2'd3
    } wr_kind_e;

    localparam int BLK16_W = 4;
    localparam int LINE_LSB_W = 5;

    typedef struct packed {
        logic page_end;
        logic line_end;
        logic blk16_end;
        logic line_legal;
        logic line_small;
        logic line_is16;
    } bnd_hits_t;

    function automatic logic line_size_legal(input logic [7:0] dw);
        return (dw == 8'd1) || (dw == 8'd2) || (dw == 8'd4) ||
               (dw == 8'd8) || (dw == 8'd16);
    endfunction

    function automatic logic is_posted(input wr_kind_e k);
        return (k == WK_POSTED) || (k == WK_INVAL);
    endfunction

endpackage

// File: rtl/burst_addr_trk.sv
module burst_addr_trk
    import wbd_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  wr_kind_e          start_kind,
    input  logic              step,
    input  logic              last,
    output logic              busy,
    output logic [ADDR_W-1:0] addr,
    output wr_kind_e          kind
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            addr <= '0;
            kind <= WK_DELAYED;
        end else if (start) begin
            busy <= 1'b1;
            addr <= start_addr;
            kind <= start_kind;
        end else if (busy && step) begin
            addr <= addr + ADDR_W'(1);
            if (last) begin
                busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bnd_decode.sv
module bnd_decode
    import wbd_pkg::*;
#(
    parameter int ADDR_W  = 30,
    parameter int CLS_W   = 8,
    parameter int PAGE_DW = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CLS_W-1:0]  cls,
    output bnd_hits_t         hits
);

    localparam int PG_W = $clog2(PAGE_DW);

    logic [7:0]            cls8;
    logic [LINE_LSB_W-1:0] line_mask;

    generate
        if (CLS_W >= 8) begin : g_wide
            assign cls8 = (|cls[CLS_W-1:0] && (cls > CLS_W'(255))) ? 8'd0 : cls[7:0];
        end else begin : g_narrow
            assign cls8 = 8'(cls);
        end
    endgenerate

    always_comb begin
        line_mask        = cls8[LINE_LSB_W-1:0] - LINE_LSB_W'(1);
        hits.line_legal  = line_size_legal(cls8);
        hits.line_is16   = (cls8 == 8'd16);
        hits.line_small  = hits.line_legal && !hits.line_is16;
        hits.page_end    = &addr[PG_W-1:0];
        hits.blk16_end   = &addr[BLK16_W-1:0];
        hits.line_end    = hits.line_legal &&
                           ((addr[LINE_LSB_W-1:0] & line_mask) == line_mask);
    end

endmodule

// File: rtl/space_guard.sv
module space_guard #(
    parameter int CLS_W  = 8,
    parameter int FREE_W = 8
) (
    input  logic [FREE_W-1:0] free_dw,
    input  logic [CLS_W-1:0]  cls,
    output logic              nearly_full,
    output logic              no_next_line
);

    localparam int CMP_W = (FREE_W > CLS_W) ? FREE_W : CLS_W;

    logic [CMP_W-1:0] free_x;
    logic [CMP_W-1:0] cls_x;

    assign free_x       = CMP_W'(free_dw);
    assign cls_x        = CMP_W'(cls);
    assign nearly_full  = (free_x <= CMP_W'(1));
    assign no_next_line = (free_x <= cls_x);

endmodule

// File: rtl/burst_disconnect_ctl.sv
module burst_disconnect_ctl
    import wbd_pkg::*;
#(
    parameter int ADDR_W  = 30,
    parameter int CLS_W   = 8,
    parameter int FREE_W  = 8,
    parameter int PAGE_DW = 1024,
    parameter int DIS_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_start,
    input  logic [1:0]        burst_kind,
    input  logic [ADDR_W-1:0] burst_addr,
    input  logic              phase_ok,
    input  logic [CLS_W-1:0]  cache_line_dw,
    input  logic [7:0]        chip_ctl,
    input  logic [FREE_W-1:0] buf_free_dw,
    output logic              disconnect,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr
);

    wr_kind_e  kind_q;
    bnd_hits_t hits;
    logic      nearly_full;
    logic      no_next_line;
    logic      line_mode;
    logic      stop_now;

    burst_addr_trk #(.ADDR_W(ADDR_W)) u_trk (
        .clk        (clk),
        .rst        (rst),
        .start      (burst_start),
        .start_addr (burst_addr),
        .start_kind (wr_kind_e'(burst_kind)),
        .step       (phase_ok),
        .last       (stop_now),
        .busy       (busy),
        .addr       (cur_addr),
        .kind       (kind_q)
    );

    bnd_decode #(.ADDR_W(ADDR_W), .CLS_W(CLS_W), .PAGE_DW(PAGE_DW)) u_bnd (
        .addr (cur_addr),
        .cls  (cache_line_dw),
        .hits (hits)
    );

    space_guard #(.CLS_W(CLS_W), .FREE_W(FREE_W)) u_space (
        .free_dw      (buf_free_dw),
        .cls          (cache_line_dw),
        .nearly_full  (nearly_full),
        .no_next_line (no_next_line)
    );

    assign line_mode = chip_ctl[DIS_BIT];

    always_comb begin
        stop_now = 1'b0;
        unique case (kind_q)
            WK_POSTED: begin
                stop_now = nearly_full || hits.page_end ||
                           (line_mode && hits.line_end);
            end
            WK_INVAL: begin
                stop_now = nearly_full || hits.page_end ||
                           (hits.line_is16 && hits.blk16_end) ||
                           (hits.line_small && hits.line_end && no_next_line);
            end
            default: begin
                stop_now = 1'b1;
            end
        endcase
    end

    assign disconnect = busy && stop_now;

endmodule

// File: rtl/wbd_checker.sv
module wbd_checker #(
    parameter int ADDR_W  = 30,
    parameter int FREE_W  = 8,
    parameter int PAGE_DW = 1024
) (
    input logic              clk,
    input logic              rst,
    input logic              burst_start,
    input logic [1:0]        burst_kind,
    input logic [ADDR_W-1:0] burst_addr,
    input logic              phase_ok,
    input logic [FREE_W-1:0] buf_free_dw,
    input logic              disconnect,
    input logic              busy,
    input logic [ADDR_W-1:0] cur_addr
);

    localparam int PG_W = $clog2(PAGE_DW);

    logic chk_dly;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_dly <= 1'b1;
        end else if (burst_start) begin
            chk_dly <= (burst_kind == 2'd0) || (burst_kind == 2'd3);
        end
    end

    a_r1_load: assert property (@(posedge clk) disable iff (rst)
        burst_start |=> busy && (cur_addr == $past(burst_addr)));

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        busy && phase_ok && !burst_start |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

    a_r3_delayed_once: assert property (@(posedge clk) disable iff (rst)
        busy && chk_dly |-> disconnect);

    a_r4_page_end: assert property (@(posedge clk) disable iff (rst)
        busy && !chk_dly && (&cur_addr[PG_W-1:0]) |-> disconnect);

    a_r9_nearly_full: assert property (@(posedge clk) disable iff (rst)
        busy && !chk_dly && (buf_free_dw <= FREE_W'(1)) |-> disconnect);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !disconnect);

    a_r10_stop_ends: assert property (@(posedge clk) disable iff (rst)
        busy && phase_ok && disconnect && !burst_start |=> !busy);

endmodule

bind burst_disconnect_ctl wbd_checker #(
    .ADDR_W(ADDR_W), .FREE_W(FREE_W), .PAGE_DW(PAGE_DW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .burst_start (burst_start),
    .burst_kind  (burst_kind),
    .burst_addr  (burst_addr),
    .phase_ok    (phase_ok),
    .buf_free_dw (buf_free_dw),
    .disconnect  (disconnect),
    .busy        (busy),
    .cur_addr    (cur_addr)
);

// File: tb/sim_burst_disconnect_ctl.sv
`timescale 1ns/1ps
module sim_burst_disconnect_ctl;

    localparam int AW = 30;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          burst_start = 1'b0;
    logic [1:0]    burst_kind = 2'd0;
    logic [AW-1:0] burst_addr = '0;
    logic          phase_ok = 1'b0;
    logic [7:0]    cache_line_dw = 8'd8;
    logic [7:0]    chip_ctl = 8'd0;
    logic [7:0]    buf_free_dw = 8'd200;
    logic          disconnect;
    logic          busy;
    logic [AW-1:0] cur_addr;

    int n_chk = 0;
    int n_bad = 0;

    int m_busy = 0;
    int m_addr = 0;
    int m_kind = 0;

    always #4 clk = ~clk;

    burst_disconnect_ctl u0 (
        .clk(clk), .rst(rst), .burst_start(burst_start), .burst_kind(burst_kind),
        .burst_addr(burst_addr), .phase_ok(phase_ok), .cache_line_dw(cache_line_dw),
        .chip_ctl(chip_ctl), .buf_free_dw(buf_free_dw), .disconnect(disconnect),
        .busy(busy), .cur_addr(cur_addr)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (addr %0d)", tag, act, exp, m_addr);
        end
    endtask

    function automatic bit legal_line(input int c);
        return c == 1 || c == 2 || c == 4 || c == 8 || c == 16;
    endfunction

    function automatic bit model_stop(output string tag);
        int  c = cache_line_dw;
        int  f = buf_free_dw;
        bit  pg = (m_addr % 1024) == 1023;
        bit  ln = legal_line(c) && ((m_addr % c) == c - 1);
        bit  oth = (chip_ctl & 8'hFD) != 0;
        tag = "R10";
        if (m_busy == 0) return 1'b0;
        if (m_kind == 0 || m_kind == 3) begin tag = "R3"; return 1'b1; end
        if (f <= 1) begin tag = "R9"; return 1'b1; end
        if (pg) begin tag = "R4"; return 1'b1; end
        if (m_kind == 1) begin
            tag = oth ? "R11" : (chip_ctl[1] ? "R5" : "R4");
            return chip_ctl[1] && ln;
        end
        if (c == 16) begin tag = "R8"; return (m_addr % 16) == 15; end
        if (legal_line(c)) begin tag = "R7"; return ln && (f <= c); end
        tag = "R6";
        return 1'b0;
    endfunction

    task automatic cyc(input bit st, input bit ph);
        string tag;
        bit    want;
        @(negedge clk);
        burst_start = st;
        phase_ok    = ph;
        #2;
        want = model_stop(tag);
        check("R1 busy", busy, m_busy);
        check("R2 cur_addr", cur_addr, m_addr);
        check({tag, " disconnect"}, disconnect, want);
        @(posedge clk);
        if (st) begin
            m_busy = 1;
            m_addr = burst_addr;
            m_kind = burst_kind;
        end else if (m_busy != 0 && ph) begin
            m_addr = (m_addr + 1) % (1 << AW);
            if (want) m_busy = 0;
        end
    endtask

    task automatic burst(input int kind, input int addr, input int nph);
        burst_kind = 2'(kind);
        burst_addr = AW'(addr);
        cyc(1'b1, 1'b0);
        for (int i = 0; i < nph; i++) cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset busy", busy, 0);
        check("R10 reset disconnect", disconnect, 0);
        check("R1 reset addr", cur_addr, 0);
        @(negedge clk);
        rst = 1'b0;

        // R3: delayed write stops after one phase
        burst(0, 5, 3);
        // R4: posted, control bit clear, crosses page end
        chip_ctl = 8'h00;
        burst(1, 1019, 7);
        // R5: posted, line mode, line size 8
        chip_ctl = 8'h02; cache_line_dw = 8'd8;
        burst(1, 3, 8);
        // R5: posted, line mode, illegal size -> page only
        cache_line_dw = 8'd6;
        burst(1, 1020, 5);
        // R11: other control bits ignored
        chip_ctl = 8'hFD; cache_line_dw = 8'd4;
        burst(1, 2048, 8);
        // R8: invalidate, 16-DWORD blocks
        chip_ctl = 8'h00; cache_line_dw = 8'd16; buf_free_dw = 8'd3;
        burst(2, 9, 9);
        // R7: invalidate, line 4, plenty of room -> page end
        cache_line_dw = 8'd4; buf_free_dw = 8'd100;
        burst(2, 1016, 10);
        // R7: invalidate, line 4, room for exactly one line -> line end
        buf_free_dw = 8'd4;
        burst(2, 0, 6);
        buf_free_dw = 8'd5;
        burst(2, 0, 6);
        // R6: invalidate, illegal size 12
        cache_line_dw = 8'd12; buf_free_dw = 8'd100;
        burst(2, 1021, 4);
        // R9: nearly full buffer on posted write
        buf_free_dw = 8'd1; chip_ctl = 8'h00;
        burst(1, 40, 2);
        buf_free_dw = 8'd3;
        burst(2, 70, 2);
        // R10 / R2: phases while idle, gaps inside a burst
        buf_free_dw = 8'd100;
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);
        burst_kind = 2'd1; burst_addr = AW'(1021);
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);
        // R1: restart in mid burst
        burst_addr = AW'(500);
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        burst_addr = AW'(800);
        cyc(1'b1, 1'b1);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule